// File: doc/BRIEF.md
# Conversion Result Window Comparator

This block sits beside an ADC and checks every finished conversion against two programmable 16-bit limits. One limit is an "above" threshold and the other is a "below" threshold. A conversion result matches when it is strictly greater than the above threshold, strictly less than the below threshold, or both, depending on how the two thresholds compare. A match sets a sticky detection flag. Software can poll the flag through the register bus or take it as a masked interrupt. Software clears the flag by writing a zero to it.

The order of the two thresholds picks the sense of the window. When the below threshold is numerically larger than the above threshold, a result matches only when it lies strictly between them, which is an inside-band detection. When the below threshold is smaller than or equal to the above threshold, a result matches when it lies above the above threshold or below the below threshold, which is an out-of-band detection. Each threshold is held as byte registers on a small byte-wide register bus. After reset the thresholds are set so that no result can ever match.

Top module: `winc_top`

## Requirements
- R1: After reset the above threshold reads 0xFFFF, the below threshold reads 0x0000, the flag and the interrupt enable read 0, and `irq_o` is 0.
- R2: The register map is as follows. Address 0 is control, with bit 0 the flag and bit 1 the interrupt enable; its other bits read 0. Address 1 is the above-threshold low byte and address 2 its high byte. Address 3 is the below-threshold low byte and address 4 its high byte. All five addresses read back what they hold through `rdata`, and addresses 5 to 7 read 0.
- R3: When below > above, a strobed result d sets the flag in the cycle after the strobe exactly if above < d < below.
- R4: When below <= above, a strobed result d sets the flag in the cycle after the strobe exactly if d > above or d < below.
- R5: Without `conv_valid` high, `conv_data` has no effect on the flag.
- R6: Once set, the flag stays set until a control write with bit 0 equal to 0. A control write with bit 0 equal to 1 leaves the flag unchanged and never sets it.
- R7: When a matching strobe and a clearing control write occur in the same cycle, the flag ends up set.
- R8: A threshold byte write takes effect from the next strobe on. A strobe in the same cycle as the write is compared against the old threshold.
- R9: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1.
- R10: With the reset thresholds, no strobed value sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| conv_valid | input | 1 | One-cycle conversion-complete strobe |
| conv_data | input | 16 | Conversion result |
| irq_o | output | 1 | Masked detection interrupt |

## Verification
The hardest cases to reach are the ones where two events land in the same clock cycle. One is a clearing control write together with a matching strobe. The other is a threshold byte write together with a strobe that the old and new thresholds would judge differently. The bench drives both of these on purpose, each in a single cycle. It also picks random results right at each threshold and one step past it, because the strict comparisons can only go wrong there. Random threshold writes move the block between the inside and outside senses, including the case where the two thresholds are equal.

// File: rtl/winc_pkg.sv
package winc_pkg;
    localparam int DEF_LIM_W = 16;

    typedef struct packed {
        logic flag;
        logic ien;
    } winc_ctrl_t;
endpackage

// File: rtl/winc_limits.sv
module winc_limits #(
    parameter int LIM_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [LIM_W-1:0]  above_o,
    output logic [LIM_W-1:0]  below_o
);
    localparam int NB = LIM_W / 8;

    typedef struct packed {
        logic [LIM_W-1:0] above;
        logic [LIM_W-1:0] below;
    } lim_t;

    lim_t lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (wr_en) begin
            for (int i = 0; i < NB; i++) begin
                if (addr == ADDR_W'(1 + i))
                    lim_d.above[8*i +: 8] = wdata;
                if (addr == ADDR_W'(1 + NB + i))
                    lim_d.below[8*i +: 8] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q.above <= '1;
            lim_q.below <= '0;
        end else begin
            lim_q <= lim_d;
        end
    end

    assign above_o = lim_q.above;
    assign below_o = lim_q.below;

    // R2: a write to the above-threshold low byte is visible on the next cycle
    assert_low_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=> (above_o[7:0] == $past(wdata)));

    // R8: without a write the thresholds are stable
    assert_limits_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(above_o) && $stable(below_o)));
endmodule

// File: rtl/winc_detect.sv
module winc_detect #(
    parameter int LIM_W = 16
) (
    input  logic             valid_i,
    input  logic [LIM_W-1:0] data_i,
    input  logic [LIM_W-1:0] above_i,
    input  logic [LIM_W-1:0] below_i,
    output logic             hit_o
);
    logic inside_mode, over, under, match;

    always_comb begin
        inside_mode = below_i > above_i;
        over        = data_i > above_i;
        under       = data_i < below_i;
        match       = inside_mode ? (over && under) : (over || under);
        hit_o       = valid_i && match;
    end
endmodule

// File: rtl/winc_ctrl.sv
module winc_ctrl #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              hit_i,
    output winc_pkg::winc_ctrl_t ctrl_o
);
    import winc_pkg::*;

    winc_ctrl_t ctrl_d, ctrl_q;
    logic       ctrl_wr;

    always_comb begin
        ctrl_d  = ctrl_q;
        ctrl_wr = wr_en && (addr == '0);
        if (ctrl_wr) begin
            ctrl_d.ien = wdata[1];
            if (!wdata[0])
                ctrl_d.flag = 1'b0;
        end
        if (hit_i)
            ctrl_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

    // R7: a detection always leaves the flag set, clear or not
    assert_hit_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> ctrl_q.flag);

    // R6: the flag only falls through a clearing control write
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.flag && !(wr_en && addr == '0 && !wdata[0])) |=> ctrl_q.flag);

    // R5: the flag only rises through a detection
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.flag && !hit_i) |=> !ctrl_q.flag);
endmodule

// File: rtl/winc_top.sv
module winc_top #(
    parameter int LIM_W  = winc_pkg::DEF_LIM_W,
    parameter int ADDR_W = $clog2(2 * (LIM_W / 8) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              conv_valid,
    input  logic [LIM_W-1:0]  conv_data,
    output logic              irq_o
);
    import winc_pkg::*;

    localparam int NB = LIM_W / 8;

    logic [LIM_W-1:0] above, below;
    logic             hit;
    winc_ctrl_t       ctrl;

    winc_limits #(.LIM_W(LIM_W), .ADDR_W(ADDR_W)) u_limits (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .above_o(above), .below_o(below)
    );

    winc_detect #(.LIM_W(LIM_W)) u_detect (
        .valid_i(conv_valid), .data_i(conv_data),
        .above_i(above), .below_i(below), .hit_o(hit)
    );

    winc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hit_i(hit), .ctrl_o(ctrl)
    );

    always_comb begin
        rdata = '0;
        if (addr == '0)
            rdata = {6'b0, ctrl.ien, ctrl.flag};
        for (int i = 0; i < NB; i++) begin
            if (addr == ADDR_W'(1 + i))
                rdata = above[8*i +: 8];
            if (addr == ADDR_W'(1 + NB + i))
                rdata = below[8*i +: 8];
        end
    end

    assign irq_o = ctrl.flag & ctrl.ien;

    // R9: a disabled interrupt stays low
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.ien |-> !irq_o);

    // R10: reset thresholds never produce a detection
    assert_default_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (above == '1 && below == '0) |-> !hit);
endmodule

// File: tb/sim_winc_top.sv
module sim_winc_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = 0;
    logic [7:0]  wdata = 0;
    logic [7:0]  rdata;
    logic        conv_valid = 0;
    logic [15:0] conv_data = 0;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] m_above, m_below;
    logic        m_flag, m_ien;

    always #5 clk = ~clk;

    winc_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .conv_valid(conv_valid), .conv_data(conv_data), .irq_o(irq_o)
    );

    function automatic bit exp_hit(logic [15:0] d, logic [15:0] a, logic [15:0] b);
        if (b > a) return (d > a) && (d < b);
        return (d > a) || (d < b);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle with optional write and strobe; model updated alongside
    task automatic cyc(bit w, logic [2:0] a, logic [7:0] wd, bit v, logic [15:0] cd);
        bit h;
        @(negedge clk);
        wr_en = w; addr = a; wdata = wd; conv_valid = v; conv_data = cd;
        h = v && exp_hit(cd, m_above, m_below);
        if (w) begin
            case (a)
                3'd0: begin m_ien = wd[1]; if (!wd[0]) m_flag = 0; end
                3'd1: m_above[7:0]  = wd;
                3'd2: m_above[15:8] = wd;
                3'd3: m_below[7:0]  = wd;
                3'd4: m_below[15:8] = wd;
                default: ;
            endcase
        end
        if (h) m_flag = 1;
        @(negedge clk);
        wr_en = 0; conv_valid = 0;
    endtask

    task automatic rd(string req, logic [2:0] a, logic [7:0] exp);
        addr = a;
        #1;
        check(req, {8'h0, rdata}, {8'h0, exp});
    endtask

    task automatic set_lim(logic [15:0] ab, logic [15:0] bl);
        cyc(1, 3'd1, ab[7:0], 0, 0);
        cyc(1, 3'd2, ab[15:8], 0, 0);
        cyc(1, 3'd3, bl[7:0], 0, 0);
        cyc(1, 3'd4, bl[15:8], 0, 0);
    endtask

    task automatic strobe_chk(string req, logic [15:0] d, bit exp_flag);
        cyc(0, 0, 0, 1, d);
        rd(req, 3'd0, {6'b0, m_ien, exp_flag});
        check(req, {15'b0, m_flag}, {15'b0, exp_flag});
        cyc(1, 3'd0, {6'b0, m_ien, 1'b0}, 0, 0);
    endtask

    function automatic string sm(bit b); return b ? "" : ""; endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_above = 16'hFFFF; m_below = 0; m_flag = 0; m_ien = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd("R1", 3'd0, 8'h00);
        rd("R1", 3'd1, 8'hFF);
        rd("R1", 3'd2, 8'hFF);
        rd("R1", 3'd3, 8'h00);
        rd("R1", 3'd4, 8'h00);
        check("R1", {15'b0, irq_o}, 0);

        // R10 reset thresholds never match
        cyc(0, 0, 0, 1, 16'h0000);
        cyc(0, 0, 0, 1, 16'hFFFF);
        cyc(0, 0, 0, 1, 16'h8000);
        rd("R10", 3'd0, 8'h00);

        // R2 readback and unmapped addresses
        set_lim(16'hA55A, 16'h3CC3);
        rd("R2", 3'd1, 8'h5A);
        rd("R2", 3'd2, 8'hA5);
        rd("R2", 3'd3, 8'hC3);
        rd("R2", 3'd4, 8'h3C);
        cyc(1, 3'd5, 8'h77, 0, 0);
        for (int a = 5; a < 8; a++) rd("R2", 3'(a), 8'h00);
        cyc(1, 3'd0, 8'hFE, 0, 0);
        rd("R2", 3'd0, 8'h02);
        cyc(1, 3'd0, 8'h00, 0, 0);

        // R3 inside window
        set_lim(16'h0100, 16'h0200);
        strobe_chk("R3", 16'h0100, 0);
        strobe_chk("R3", 16'h0101, 1);
        strobe_chk("R3", 16'h0200, 0);
        strobe_chk("R3", 16'h01FF, 1);

        // R4 outside window, including equal thresholds
        set_lim(16'h0200, 16'h0100);
        strobe_chk("R4", 16'h0150, 0);
        strobe_chk("R4", 16'h0201, 1);
        strobe_chk("R4", 16'h00FF, 1);
        strobe_chk("R4", 16'h0100, 0);
        set_lim(16'h0300, 16'h0300);
        strobe_chk("R4", 16'h0300, 0);
        strobe_chk("R4", 16'h0301, 1);
        strobe_chk("R4", 16'h02FF, 1);

        // R5 data without strobe ignored
        cyc(0, 0, 0, 0, 16'hFFFF);
        rd("R5", 3'd0, 8'h00);

        // R6 sticky; writing 1 keeps it; writing 1 never sets it
        cyc(1, 3'd0, 8'h01, 0, 0);
        rd("R6", 3'd0, 8'h00);
        cyc(0, 0, 0, 1, 16'hFFFF);
        cyc(0, 0, 0, 0, 0);
        cyc(1, 3'd0, 8'h01, 0, 0);
        rd("R6", 3'd0, 8'h01);
        cyc(1, 3'd0, 8'h00, 0, 0);
        rd("R6", 3'd0, 8'h00);

        // R7 set beats clear in the same cycle
        cyc(0, 0, 0, 1, 16'hFFFF);
        cyc(1, 3'd0, 8'h00, 1, 16'h0000);
        rd("R7", 3'd0, 8'h01);

        // R9 interrupt masking
        check("R9", {15'b0, irq_o}, 0);
        cyc(1, 3'd0, 8'h03, 0, 0);
        check("R9", {15'b0, irq_o}, 1);
        cyc(1, 3'd0, 8'h02, 0, 0);
        check("R9", {15'b0, irq_o}, 0);
        cyc(1, 3'd0, 8'h00, 0, 0);

        // R8 same-cycle threshold write uses old value
        set_lim(16'h1000, 16'h0000);
        cyc(1, 3'd2, 8'h07, 1, 16'h0800);
        rd("R8", 3'd0, 8'h00);
        cyc(0, 0, 0, 1, 16'h0800);
        rd("R8", 3'd0, 8'h01);
        cyc(1, 3'd0, 8'h00, 0, 0);

        // random mix against the model (R3 R4 R6 R9)
        for (int it = 0; it < 600; it++) begin
            int k;
            logic [15:0] d;
            k = $urandom % 4;
            if (k == 0) begin
                cyc(1, 3'(1 + $urandom % 4), 8'($urandom), 0, 0);
            end else if (k == 1) begin
                case ($urandom % 5)
                    0: d = m_above;
                    1: d = m_above + 16'd1;
                    2: d = m_below;
                    3: d = m_below - 16'd1;
                    default: d = 16'($urandom);
                endcase
                cyc(0, 0, 0, 1, d);
            end else if (k == 2) begin
                cyc(1, 3'd0, 8'($urandom % 4), ($urandom % 2) == 1, 16'($urandom));
            end else begin
                cyc(0, 0, 0, 0, 16'($urandom));
            end
            rd("R3/R4 random", 3'd0, {6'b0, m_ien, m_flag});
            check("R9 random", {15'b0, irq_o}, {15'b0, m_flag & m_ien});
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule